// File: doc/BRIEF.md
# Conditional Branch Colour and Squash Controller

This block sits beside the bytecode-to-micro-instruction translation stage and deals with the instructions that are issued past a conditional branch before that branch resolves. A fetched word can hold several bytecodes, so the bytes after a conditional branch may already be translated and sent down the pipeline when the condition is known. Pipeline flush wires are not used. Every dispatched micro-instruction instead carries a one-bit colour taken from a colour register. A taken resolution inverts that register, and the execute-side filter then drops every instruction that still carries the old colour.

When the decoder issues a conditional branch, the block does three things. It requests a full flush of the operand stack cache. It forms the branch target from the byte address of the branch opcode plus a signed 16-bit offset built from the two operand bytes. It then raises a stall so that no second conditional branch can issue before this one resolves. A taken resolution produces a one-cycle redirect to the stored target for the fetch buffer. A not-taken resolution only releases the stall.

Top module: `bcs_ctrl`

## Requirements
- R1: After reset, the colour is 0 and `issue_stall`, `flush_req` and `redirect_valid` are all low.
- R2: When `br_issue` is high and `issue_stall` is low at a clock edge, `flush_req` is high for exactly the next cycle and `issue_stall` is high from the next cycle on.
- R3: A `br_issue` that arrives while `issue_stall` is high is ignored. It causes no `flush_req` and does not change the stored target that a later taken resolution redirects to.
- R4: The target is `br_op_addr` plus the sign-extended 16-bit value {`br_off_hi`, `br_off_lo`}. `br_off_hi` supplies bits 15:8, and the sum wraps modulo 2^ADDR_W.
- R5: When `res_valid` is high, `res_taken` is high and `issue_stall` is high at an edge, the next cycle shows `redirect_valid` high for one cycle, `redirect_addr` equal to the stored target, the colour inverted and `issue_stall` low.
- R6: A not-taken resolution (`res_valid` high, `res_taken` low, while stalled) clears `issue_stall` in the next cycle. `redirect_valid` stays low and the colour is unchanged.
- R7: A `res_valid` that arrives while `issue_stall` is low has no effect on the colour, `redirect_valid` or `issue_stall`.
- R8: `uop_colour` always equals the current colour register, and it changes only in a cycle that also shows `redirect_valid`.
- R9: `ex_accept` is high exactly when `ex_valid` is high and `ex_colour` equals the current colour. In the cycle in which a taken resolution arrives, the comparison still uses the colour that was in place before the resolution.
- R10: `flush_req` and `redirect_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_issue | input | 1 | Decoder issues a conditional branch |
| br_op_addr | input | ADDR_W | Byte address of the branch opcode |
| br_off_hi | input | 8 | First operand byte, bits 15:8 of the offset |
| br_off_lo | input | 8 | Second operand byte, bits 7:0 of the offset |
| res_valid | input | 1 | Branch resolution strobe |
| res_taken | input | 1 | Resolution outcome, 1 = taken |
| ex_valid | input | 1 | Execute stage presents a micro-instruction |
| ex_colour | input | 1 | Colour tag of that micro-instruction |
| issue_stall | output | 1 | A branch is outstanding; hold further branch issue |
| flush_req | output | 1 | One-cycle stack-cache flush request |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | ADDR_W | Redirect target |
| uop_colour | output | 1 | Colour to attach to dispatched micro-instructions |
| ex_accept | output | 1 | Execute may commit the presented micro-instruction |

## Verification
Two functions can fall in the same cycle: the execute-side filter decision and a taken resolution that inverts the colour. The bench provokes this by driving `ex_valid` with the old colour in the same cycle as the taken resolution. It samples `ex_accept` before the edge and expects acceptance, then drives the same tag after the edge and expects rejection. A second overlap is a new branch issue that lands in the resolution cycle. That issue must be stalled away, and the bench judges this by the absence of any flush afterwards.

// File: rtl/bcs_pkg.sv
// Shared definitions for the branch colour/squash controller.
// Assumes a 16-bit signed branch offset made of two operand bytes.
package bcs_pkg;
    localparam int OFF_W = 16;

    typedef enum logic {
        BR_IDLE    = 1'b0,
        BR_PENDING = 1'b1
    } br_state_e;
endpackage

// File: rtl/bcs_target.sv
// Forms the relative branch target from the opcode byte address and a
// signed offset. The operand bytes arrive high byte first. Pure
// combinational logic; the sum wraps at the address width.
module bcs_target #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        off_hi,
    input  logic [7:0]        off_lo,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - bcs_pkg::OFF_W;

    logic [bcs_pkg::OFF_W-1:0] off16;
    logic [ADDR_W-1:0]         off_ext;

    // Join the bytes and sign-extend to the address width, then add.
    always_comb begin
        off16   = {off_hi, off_lo};
        off_ext = {{EXT_W{off16[bcs_pkg::OFF_W-1]}}, off16};
        target  = op_addr + off_ext;
    end
endmodule

// File: rtl/bcs_tracker.sv
// Tracks the single outstanding conditional branch. It holds the target,
// raises the flush and redirect pulses, and owns the colour register.
// Assumes that resolutions arriving with no branch outstanding are stray
// and may be dropped.
module bcs_tracker #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_issue,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              res_valid,
    input  logic              res_taken,
    output logic              busy,
    output logic              flush_req,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              colour
);
    import bcs_pkg::*;

    br_state_e         state;
    logic [ADDR_W-1:0] tgt_q;
    logic              accept_issue;
    logic              accept_res;

    // Decide which events are accepted in this cycle.
    always_comb begin
        accept_issue = br_issue && (state == BR_IDLE);
        accept_res   = res_valid && (state == BR_PENDING);
    end

    // Sequence the branch state, pulses, target and colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= BR_IDLE;
            tgt_q          <= '0;
            flush_req      <= 1'b0;
            redirect_valid <= 1'b0;
            colour         <= 1'b0;
        end else begin
            flush_req      <= 1'b0;
            redirect_valid <= 1'b0;
            if (accept_issue) begin
                state     <= BR_PENDING;
                tgt_q     <= tgt_in;
                flush_req <= 1'b1;
            end else if (accept_res) begin
                state <= BR_IDLE;
                if (res_taken) begin
                    redirect_valid <= 1'b1;
                    colour         <= ~colour;
                end
            end
        end
    end

    // Expose the stall and the stored target.
    always_comb begin
        busy          = (state == BR_PENDING);
        redirect_addr = tgt_q;
    end
endmodule

// File: rtl/bcs_filter.sv
// Execute-side squash filter. It passes a micro-instruction only when its
// colour tag matches the live colour. Combinational logic, so it uses the
// colour as it stands before any toggle at the coming edge.
module bcs_filter (
    input  logic ex_valid,
    input  logic ex_colour,
    input  logic cur_colour,
    output logic ex_accept
);
    // Compare the tag against the live colour.
    always_comb begin
        ex_accept = ex_valid && (ex_colour == cur_colour);
    end
endmodule

// File: rtl/bcs_ctrl.sv
// Top level of the branch colour/squash controller. It joins the target
// adder, the outstanding-branch tracker and the execute filter.
// Assumes the decoder obeys issue_stall; an issue made while stalled is
// ignored.
module bcs_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_issue,
    input  logic [ADDR_W-1:0] br_op_addr,
    input  logic [7:0]        br_off_hi,
    input  logic [7:0]        br_off_lo,
    input  logic              res_valid,
    input  logic              res_taken,
    input  logic              ex_valid,
    input  logic              ex_colour,
    output logic              issue_stall,
    output logic              flush_req,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              uop_colour,
    output logic              ex_accept
);
    logic [ADDR_W-1:0] tgt;
    logic              colour;

    bcs_target #(.ADDR_W(ADDR_W)) u_target (
        .op_addr (br_op_addr),
        .off_hi  (br_off_hi),
        .off_lo  (br_off_lo),
        .target  (tgt)
    );

    bcs_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .br_issue       (br_issue),
        .tgt_in         (tgt),
        .res_valid      (res_valid),
        .res_taken      (res_taken),
        .busy           (issue_stall),
        .flush_req      (flush_req),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr),
        .colour         (colour)
    );

    bcs_filter u_filter (
        .ex_valid   (ex_valid),
        .ex_colour  (ex_colour),
        .cur_colour (colour),
        .ex_accept  (ex_accept)
    );

    // Tag outgoing micro-instructions with the live colour.
    always_comb uop_colour = colour;
endmodule

// File: rtl/bcs_ctrl_chk.sv
// Property checker for bcs_ctrl, attached through bind below.
module bcs_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic br_issue,
    input logic res_valid,
    input logic res_taken,
    input logic ex_valid,
    input logic ex_colour,
    input logic issue_stall,
    input logic flush_req,
    input logic redirect_valid,
    input logic uop_colour,
    input logic ex_accept
);
    // R2
    flush_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_issue && !issue_stall) |=> (flush_req && issue_stall));

    // R3
    no_flush_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_stall) |=> !flush_req);

    // R5
    taken_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && issue_stall) |=> (redirect_valid && !issue_stall));

    // R6
    not_taken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && issue_stall) |=> (!redirect_valid && $stable(uop_colour)));

    // R7
    stray_resolution_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !issue_stall) |=> (!redirect_valid && $stable(uop_colour)));

    // R8
    colour_moves_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(uop_colour) |-> redirect_valid);

    // R9
    reject_stale_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_colour != uop_colour)) |-> !ex_accept);

    // R10
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, redirect_valid}));
endmodule

bind bcs_ctrl bcs_ctrl_chk u_bcs_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_issue       (br_issue),
    .res_valid      (res_valid),
    .res_taken      (res_taken),
    .ex_valid       (ex_valid),
    .ex_colour      (ex_colour),
    .issue_stall    (issue_stall),
    .flush_req      (flush_req),
    .redirect_valid (redirect_valid),
    .uop_colour     (uop_colour),
    .ex_accept      (ex_accept)
);

// File: tb/test_bcs_ctrl.sv
module test_bcs_ctrl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_issue = 1'b0;
    logic [AW-1:0] br_op_addr = '0;
    logic [7:0]    br_off_hi = '0;
    logic [7:0]    br_off_lo = '0;
    logic          res_valid = 1'b0;
    logic          res_taken = 1'b0;
    logic          ex_valid = 1'b0;
    logic          ex_colour = 1'b0;
    logic          issue_stall, flush_req, redirect_valid, uop_colour, ex_accept;
    logic [AW-1:0] redirect_addr;

    int checks = 0;
    int errors = 0;
    logic exp_col = 1'b0;

    always #10 clk = ~clk;

    bcs_ctrl #(.ADDR_W(AW)) i_bcs_ctrl (
        .clk(clk), .rst_n(rst_n), .br_issue(br_issue), .br_op_addr(br_op_addr),
        .br_off_hi(br_off_hi), .br_off_lo(br_off_lo), .res_valid(res_valid),
        .res_taken(res_taken), .ex_valid(ex_valid), .ex_colour(ex_colour),
        .issue_stall(issue_stall), .flush_req(flush_req),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .uop_colour(uop_colour), .ex_accept(ex_accept)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 ns after it, away from the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [15:0] off);
        br_issue = 1'b1; br_op_addr = a; br_off_hi = off[15:8]; br_off_lo = off[7:0];
        step();
        br_issue = 1'b0;
    endtask

    task automatic resolve(input logic taken);
        res_valid = 1'b1; res_taken = taken;
        step();
        res_valid = 1'b0; res_taken = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 colour", AW'(uop_colour), '0);
        chk("R1 stall", AW'(issue_stall), '0);
        chk("R1 flush", AW'(flush_req), '0);
        chk("R1 redirect", AW'(redirect_valid), '0);
    endtask

    task automatic t_taken_forward();
        issue(32'h0000_1000, 16'h0024);
        chk("R2 flush pulse", AW'(flush_req), 1);
        chk("R2 stall set", AW'(issue_stall), 1);
        step();
        chk("R2 flush one cycle", AW'(flush_req), 0);
        resolve(1'b1);
        exp_col = ~exp_col;
        chk("R5 redirect", AW'(redirect_valid), 1);
        chk("R4 R5 target", redirect_addr, 32'h0000_1024);
        chk("R5 colour toggled", AW'(uop_colour), AW'(exp_col));
        chk("R5 stall cleared", AW'(issue_stall), 0);
        step();
        chk("R5 redirect one cycle", AW'(redirect_valid), 0);
    endtask

    task automatic t_not_taken();
        issue(32'h0000_2000, 16'h0010);
        resolve(1'b0);
        chk("R6 no redirect", AW'(redirect_valid), 0);
        chk("R6 colour kept", AW'(uop_colour), AW'(exp_col));
        chk("R6 stall cleared", AW'(issue_stall), 0);
    endtask

    task automatic t_stalled_issue();
        issue(32'h0000_3000, 16'h0002);
        step();
        issue(32'h0000_9000, 16'h0100);
        chk("R3 no flush", AW'(flush_req), 0);
        resolve(1'b1);
        exp_col = ~exp_col;
        chk("R3 target kept", redirect_addr, 32'h0000_3002);
        step();
    endtask

    task automatic t_negative_wrap();
        issue(32'h0000_1000, 16'h8000);
        resolve(1'b1);
        exp_col = ~exp_col;
        chk("R4 negative offset", redirect_addr, 32'hFFFF_9000);
        issue(32'hFFFF_FFFE, 16'h0004);
        resolve(1'b1);
        exp_col = ~exp_col;
        chk("R4 wrap", redirect_addr, 32'h0000_0002);
        chk("R8 uop colour", AW'(uop_colour), AW'(exp_col));
    endtask

    task automatic t_stray_resolution();
        step();
        resolve(1'b1);
        chk("R7 no redirect", AW'(redirect_valid), 0);
        chk("R7 colour kept", AW'(uop_colour), AW'(exp_col));
        chk("R7 no stall", AW'(issue_stall), 0);
    endtask

    task automatic t_same_cycle_filter();
        issue(32'h0000_4000, 16'h0008);
        ex_valid = 1'b1; ex_colour = exp_col;
        #2;
        chk("R9 match accepted", AW'(ex_accept), 1);
        ex_colour = ~exp_col;
        #2;
        chk("R9 mismatch dropped", AW'(ex_accept), 0);
        // taken resolution together with an old-colour instruction and a new issue
        ex_colour = exp_col; res_valid = 1'b1; res_taken = 1'b1;
        br_issue = 1'b1; br_op_addr = 32'h0000_7000;
        #2;
        chk("R9 old colour in resolve cycle", AW'(ex_accept), 1);
        step();
        res_valid = 1'b0; res_taken = 1'b0; br_issue = 1'b0;
        exp_col = ~exp_col;
        chk("R10 no flush with redirect", AW'(flush_req), 0);
        chk("R9 old colour now dropped", AW'(ex_accept), 0);
        chk("R3 issue in resolve cycle ignored", AW'(issue_stall), 0);
        ex_valid = 1'b0;
        step();
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_taken_forward();
        t_not_taken();
        t_stalled_issue();
        t_negative_wrap();
        t_stray_resolution();
        t_same_cycle_filter();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule